// File: doc/BRIEF.md
# Blanked Pipelined Pixel Output Stage

This block is the digital back end of an image sensor conversion path. Each sample clock it takes one 14-bit pixel word, carries it through a fixed chain of nine registers and presents it on the output data bus, so a word shows up exactly nine sample clocks after it was taken. A preblanking strobe that comes in with a sample forces that sample to read as zero when it leaves the chain. A black-clamp strobe cancels blanking: a sample taken while both strobes are high is not zeroed, so blanking never disturbs the clamp interval.

Two register fields control the block. A two-bit operating mode selects standby (code 0) or one of three active codes (1, 2, 3), which all behave the same here. In standby the chain freezes, the bus reads zero and a standby flag is raised. A disable bit lowers the bus-enable output so that the pad driver releases the bus. The pipeline keeps running while the bus is released.

Top module: `pixout_stage`

## Requirements
- R1: A word presented on `samp_in` before a rising clock edge in an active mode appears on `dbus` after the ninth rising edge, counting that edge, provided every edge in between is in an active mode.
- R2: A word taken with `blank_in`=1 and `clamp_in`=0 comes out as all zeros in the cycle it would otherwise have appeared. Words next to it are not affected.
- R3: A word taken with `clamp_in`=1 comes out unchanged whatever the value of `blank_in`.
- R4: With `blank_in` held at 0, every word comes out unchanged.
- R5: `bus_oe` is the inverse of `out_dis` in the same cycle. `out_dis` has no effect on the word sequence seen on `dbus`.
- R6: While `op_mode`=0, `stby_o`=1 and `dbus` reads all zeros. In modes 1, 2 and 3, `stby_o`=0.
- R7: Clock edges in standby do not move the chain. When the block returns to an active mode, the words held in the chain come out in order, with no word lost or repeated.
- R8: A synchronous reset (`rst`=1 at a rising edge) clears every stage. Until new words reach the end of the chain, `dbus` reads zero.
- R9: Modes 1, 2 and 3 produce identical output for identical input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| samp_in | input | 14 | Converted pixel word |
| blank_in | input | 1 | Preblanking strobe for the current sample |
| clamp_in | input | 1 | Black-clamp strobe for the current sample; cancels blanking |
| op_mode | input | 2 | Operating mode; 0 = standby, 1/2/3 = active |
| out_dis | input | 1 | 1 releases the data bus |
| dbus | output | 14 | Delayed, blanked pixel word |
| bus_oe | output | 1 | Drive enable for the data bus pads |
| stby_o | output | 1 | High while in standby |

## Verification
The bench targets single-cycle blanking pulses and blanking strobes that partly overlap a clamp window. A design that ran the strobe through a chain one stage too short or too long would zero the word next to the correct one, and a design that let blanking win would zero clamp pixels. Standby is entered while blanked words are in the chain, and the bench checks that they come out in order after resuming. A chain that kept shifting, or one that lost its contents, would skip or repeat words. A reset in the middle of a run is also checked: stale words must not leak out during the nine cycles after it.

// File: rtl/pixout_pkg.sv
package pixout_pkg;

    localparam int unsigned PIX_W   = 14;
    localparam int unsigned PIX_LAT = 9;

    typedef enum logic [1:0] {
        MODE_STBY    = 2'd0,
        MODE_ACT_A   = 2'd1,
        MODE_ACT_TST = 2'd2,
        MODE_ACT_B   = 2'd3
    } opmode_e;

    // One pipeline slot: the word and the blanking decision made on entry
    typedef struct packed {
        logic [PIX_W-1:0] word;
        logic             blank;
    } pix_t;

    function automatic logic [PIX_W-1:0] apply_blank(pix_t p);
        return p.blank ? '0 : p.word;
    endfunction

endpackage

// File: rtl/pixout_ctrl.sv
module pixout_ctrl
    import pixout_pkg::*;
(
    input  logic [1:0] op_mode,
    input  logic       out_dis,
    input  logic       blank_in,
    input  logic       clamp_in,
    output logic       stby,
    output logic       adv,
    output logic       oe,
    output logic       blank_eff
);

    opmode_e mode;

    always_comb begin
        mode      = opmode_e'(op_mode);
        stby      = (mode == MODE_STBY);
        adv       = !stby;
        oe        = !out_dis;
        // Clamp window has priority over preblanking
        blank_eff = blank_in && !clamp_in;
    end

endmodule

// File: rtl/pixout_pipe.sv
module pixout_pipe
    import pixout_pkg::*;
#(
    parameter int unsigned DEPTH = PIX_LAT
)(
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  pix_t head_in,
    output pix_t head_o,
    output pix_t tail_o
);

    localparam int unsigned LAST = DEPTH - 1;

    for (genvar i = 0; i < DEPTH; i++) begin : g_stg
        pix_t q;
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst)      q <= '0;
                else if (adv) q <= head_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst)      q <= '0;
                else if (adv) q <= g_stg[i-1].q;
            end
        end
    end

    assign head_o = g_stg[0].q;
    assign tail_o = g_stg[LAST].q;

    AST_HOLD_IN_STANDBY: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(tail_o)); // R7

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (tail_o == '0 && head_o == '0)); // R8

endmodule

// File: rtl/pixout_out.sv
module pixout_out
    import pixout_pkg::*;
(
    input  logic             stby,
    input  pix_t             tail,
    output logic [PIX_W-1:0] word_o
);

    always_comb begin
        if (stby) word_o = '0;
        else      word_o = apply_blank(tail);
    end

endmodule

// File: rtl/pixout_stage.sv
module pixout_stage
    import pixout_pkg::*;
#(
    parameter int unsigned LAT = PIX_LAT
)(
    input  logic             clk,
    input  logic             rst,
    input  logic [PIX_W-1:0] samp_in,
    input  logic             blank_in,
    input  logic             clamp_in,
    input  logic [1:0]       op_mode,
    input  logic             out_dis,
    output logic [PIX_W-1:0] dbus,
    output logic             bus_oe,
    output logic             stby_o
);

    logic stby, adv, oe, blank_eff;
    pix_t entry, head, tail;

    pixout_ctrl u_ctrl (
        .op_mode   (op_mode),
        .out_dis   (out_dis),
        .blank_in  (blank_in),
        .clamp_in  (clamp_in),
        .stby      (stby),
        .adv       (adv),
        .oe        (oe),
        .blank_eff (blank_eff)
    );

    always_comb begin
        entry.word  = samp_in;
        entry.blank = blank_eff;
    end

    pixout_pipe #(.DEPTH(LAT)) u_pipe (
        .clk     (clk),
        .rst     (rst),
        .adv     (adv),
        .head_in (entry),
        .head_o  (head),
        .tail_o  (tail)
    );

    pixout_out u_out (
        .stby   (stby),
        .tail   (tail),
        .word_o (dbus)
    );

    assign bus_oe = oe;
    assign stby_o = stby;

    AST_STANDBY_ZERO: assert property (@(posedge clk) disable iff (rst)
        (op_mode == 2'd0) |-> (dbus == '0 && stby_o)); // R6

    AST_CLAMP_OVER_BLANK: assert property (@(posedge clk) disable iff (rst)
        (clamp_in && op_mode != 2'd0) |=> !head.blank); // R3

    AST_RELEASE_BUS: assert property (@(posedge clk) disable iff (rst)
        out_dis |-> !bus_oe); // R5

endmodule

// File: tb/pixout_stage_tb.sv
module pixout_stage_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 9;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] samp_in = '0;
    logic        blank_in = 1'b0;
    logic        clamp_in = 1'b0;
    logic [1:0]  op_mode = 2'd1;
    logic        out_dis = 1'b0;
    logic [13:0] dbus;
    logic        bus_oe;
    logic        stby_o;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    // Reference: queue of {word, zeroed-flag}, oldest at the back
    logic [14:0] ref_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    pixout_stage dut_i (
        .clk      (clk),
        .rst      (rst),
        .samp_in  (samp_in),
        .blank_in (blank_in),
        .clamp_in (clamp_in),
        .op_mode  (op_mode),
        .out_dis  (out_dis),
        .dbus     (dbus),
        .bus_oe   (bus_oe),
        .stby_o   (stby_o)
    );

    function automatic void ref_clear();
        ref_q.delete();
        for (int i = 0; i < LAT; i++) ref_q.push_front(15'd0);
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic cyc(input string tag, input logic [13:0] d, input logic b, input logic c,
                       input logic [1:0] m, input logic od, input logic r, input bit chk);
        logic [14:0] last;
        logic [13:0] exp_word;
        @(negedge clk);
        samp_in = d; blank_in = b; clamp_in = c; op_mode = m; out_dis = od; rst = r;
        #1;
        if (chk) begin
            last = ref_q[LAT-1];
            exp_word = (m == 2'd0 || last[0]) ? 14'd0 : last[14:1];
            check(tag, "dbus", int'(dbus), int'(exp_word));
            check(tag, "bus_oe", int'(bus_oe), int'(!od));
            check(tag, "stby_o", int'(stby_o), int'(m == 2'd0));
        end
        if (r) ref_clear();
        else if (m != 2'd0) begin
            void'(ref_q.pop_back());
            ref_q.push_front({d, b & ~c});
        end
    endtask

    initial begin
        ref_clear();
        cyc("R8", 14'h1abc, 1'b0, 1'b0, 2'd1, 1'b0, 1'b1, 1'b0);
        for (int i = 0; i < 3; i++) cyc("R8", 14'h2222, 1'b0, 1'b0, 2'd1, 1'b0, 1'b1, 1'b1);
        // R8: zeros drain out before first real word; R1 ramp with latency marker
        for (int i = 0; i < 20; i++) cyc("R1", 14'(i * 37 + 5), 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1);
        // R4: random words, no blanking, other active mode
        for (int i = 0; i < 30; i++) cyc("R4", 14'($urandom), 1'b0, 1'b0, 2'd3, 1'b0, 1'b0, 1'b1);
        // R2: single-cycle and multi-cycle blanking pulses
        for (int i = 0; i < 40; i++)
            cyc("R2", 14'($urandom) | 14'h1, (i % 7 == 3) || (i >= 20 && i < 25), 1'b0, 2'd1, 1'b0, 1'b0, 1'b1);
        // R3: clamp window overlapping blanking on both edges
        for (int i = 0; i < 40; i++)
            cyc("R3", 14'($urandom) | 14'h2, (i >= 5 && i < 30), (i >= 10 && i < 22), 2'd1, 1'b0, 1'b0, 1'b1);
        // R5: bus release toggling while data flows
        for (int i = 0; i < 30; i++)
            cyc("R5", 14'($urandom), (i % 5 == 0), 1'b0, 2'd3, (i % 3 == 1), 1'b0, 1'b1);
        // R6 / R7: fill with blanked and live words, freeze, then resume
        for (int i = 0; i < 6; i++) cyc("R7", 14'h0100 + 14'(i), (i == 2), 1'b0, 2'd1, 1'b0, 1'b0, 1'b1);
        for (int i = 0; i < 12; i++) cyc("R6", 14'($urandom), (i % 2 == 0), 1'b0, 2'd0, (i == 4), 1'b0, 1'b1);
        for (int i = 0; i < 20; i++) cyc("R7", 14'h0200 + 14'(i), 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1);
        // R9: test-code mode behaves as active
        for (int i = 0; i < 25; i++) cyc("R9", 14'($urandom), (i % 4 == 1), (i % 8 == 1), 2'd2, 1'b0, 1'b0, 1'b1);
        // R8: reset in mid-run, stale words must not leak
        for (int i = 0; i < 2; i++) cyc("R8", 14'h3fff, 1'b0, 1'b0, 2'd1, 1'b0, 1'b1, 1'b1);
        for (int i = 0; i < 15; i++) cyc("R8", 14'h0a00 + 14'(i), 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 1'b1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule